// File: doc/BRIEF.md
# Noise-Tolerant 16x16 Multiplier with Truncated Replica

This block multiplies two 16-bit unsigned operands and guards the result against large errors in the main product. A full-precision array multiplier produces the exact 32-bit product. Beside it, a small replica multiplier works only on the upper byte of each operand. Its partial-product array is truncated to a fixed width: it keeps only the upper eight product columns. Instead of the dropped columns it adds a variable compensation term. Part of that term is the heaviest dropped column, fed straight into the lowest kept column. The rest is a one-bit minor correction taken from the next dropped column. This compensation is summed in parallel with the kept terms, so it adds no depth to the longest adder chain.

A decision stage aligns the 8-bit replica result with bits [31:24] of the product and fills the lower bits with zeros. It then compares this estimate with the main product. When the two differ by more than a threshold set at an input, the estimate replaces the main product and a flag is raised. A test input XORs an error pattern into the main product, which stands in for timing faults in the main array. The whole datapath has one register stage, loaded when the input is valid.

Top module: `ant_trunc_mult`

## Requirements
- R1: `res_valid` rises one clock after `op_valid` is sampled high and is low one clock after it is sampled low. Reset clears `res_valid`, `res_prod` and `res_alt` to 0.
- R2: The main path gives the exact unsigned product `op_a*op_b`. With `fault_xor`=0 and `thr` at least 2^29-1, `res_prod` equals that exact product and `res_alt` is 0.
- R3: Let p=`op_a[15:8]` and q=`op_b[15:8]`. The replica value S is the sum of three parts: every p[i]&q[j] with i+j>=8, weighted 2^(i+j-8); every p[i]&q[j] with i+j=7, weighted 1; and (p[6]&q[0])|(p[0]&q[6]), weighted 1. S saturates at 255. The aligned estimate is S<<24.
- R4: For `op_a`=`op_b`=16'hFFFF, S saturates and the aligned estimate is 32'hFF000000.
- R5: Let M=(`op_a*op_b`)^`fault_xor` and E be the aligned estimate. The estimate is selected only when |M-E| > `thr`. When |M-E| = `thr`, M is output.
- R6: `res_alt` is 1 exactly when the estimate was selected. While it is 1, `res_prod[23:0]` is 0.
- R7: While `op_valid` is low, `res_prod` and `res_alt` keep their previous values.
- R8: When `thr`=2^29-1 and the estimate is selected, |`res_prod` - exact product| < 2^29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operands valid; loads the result register |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| thr | input | 32 | Difference threshold for choosing the estimate |
| fault_xor | input | 32 | Test pattern XORed into the main product |
| res_valid | output | 1 | Result valid |
| res_prod | output | 32 | Selected product |
| res_alt | output | 1 | High when the replica estimate was selected |

## Verification
Every result appears in the single register one clock after the operands are sampled. The bench drives operands on a falling edge and compares `res_prod`, `res_alt` and `res_valid` at the next falling edge, half a period after the capturing rising edge. Hold behaviour is checked one falling edge after an idle cycle with changed operands. The test bench recomputes the compensated replica value from the column rule alone and checks it on its own. Random operands and high-byte fault patterns are mixed with directed all-ones, zero and threshold-equality cases.

// File: rtl/ant_pkg.sv
package ant_pkg;
  localparam int OP_W  = 16;
  localparam int REP_W = 8;
  localparam int PR_W  = 2 * OP_W;
  typedef logic [PR_W-1:0] prod_t;
endpackage

// File: rtl/ant_main_array.sv
module ant_main_array #(
  parameter int W = 16
) (
  input  logic [W-1:0]   mul_a,
  input  logic [W-1:0]   mul_b,
  output logic [2*W-1:0] mul_p
);
  localparam int PW = 2 * W;

  logic [PW-1:0] row [W];
  logic [PW-1:0] acc [W];

  // one partial-product row per multiplier bit, shifted to its weight
  for (genvar r = 0; r < W; r++) begin : g_row
    assign row[r] = {{W{1'b0}}, (mul_a & {W{mul_b[r]}})} << r;
  end

  assign acc[0] = row[0];
  for (genvar k = 1; k < W; k++) begin : g_acc
    assign acc[k] = acc[k-1] + row[k];
  end

  assign mul_p = acc[W-1];
endmodule

// File: rtl/ant_trunc_replica.sv
module ant_trunc_replica #(
  parameter int N = 8
) (
  input  logic [N-1:0] rp_a,
  input  logic [N-1:0] rp_b,
  output logic [N-1:0] rp_q
);
  localparam int SW = N + 3;

  logic [N-1:0] pp [N];
  logic [SW-1:0] kept_sum;
  logic [SW-1:0] icv_sum;
  logic          minor_bit;
  logic [SW-1:0] total;

  for (genvar i = 0; i < N; i++) begin : g_pp
    assign pp[i] = rp_b & {N{rp_a[i]}};
  end

  // kept columns (weight >= N), expressed in units of 2^N
  always_comb begin
    kept_sum = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i + j >= N) begin
          kept_sum = kept_sum + (SW'(pp[i][j]) << (i + j - N));
        end
      end
    end
  end

  // heaviest dropped column, injected at the lowest kept weight;
  // summed in parallel with the kept array
  always_comb begin
    icv_sum = '0;
    for (int i = 0; i < N; i++) begin
      icv_sum = icv_sum + SW'(pp[i][N-1-i]);
    end
  end

  // minor correction from the two outermost terms of the next column
  assign minor_bit = pp[N-2][0] | pp[0][N-2];

  assign total = kept_sum + icv_sum + SW'(minor_bit);
  assign rp_q  = (total > SW'((1 << N) - 1)) ? {N{1'b1}} : total[N-1:0];
endmodule

// File: rtl/ant_decider.sv
module ant_decider #(
  parameter int PW = 32,
  parameter int RW = 8
) (
  input  logic [PW-1:0] dc_main,
  input  logic [RW-1:0] dc_rep,
  input  logic [PW-1:0] dc_thr,
  output logic [PW-1:0] dc_out,
  output logic          dc_alt
);
  logic [PW-1:0] est;
  logic [PW-1:0] diff;

  assign est  = {dc_rep, {(PW-RW){1'b0}}};
  assign diff = (dc_main >= est) ? (dc_main - est) : (est - dc_main);

  always_comb begin
    dc_alt = (diff > dc_thr);
    dc_out = dc_alt ? est : dc_main;
  end
endmodule

// File: rtl/ant_trunc_mult.sv
module ant_trunc_mult
  import ant_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [PR_W-1:0]  thr,
  input  logic [PR_W-1:0]  fault_xor,
  output logic             res_valid,
  output logic [PR_W-1:0]  res_prod,
  output logic             res_alt
);
  prod_t              exact_p;
  prod_t              main_p;
  logic [REP_W-1:0]   rep_q;
  prod_t              sel_p;
  logic               sel_alt;

  prod_t              prod_d;
  logic               alt_d;
  logic               valid_d;

  ant_main_array #(.W(OP_W)) u_main (
    .mul_a (op_a),
    .mul_b (op_b),
    .mul_p (exact_p)
  );

  assign main_p = exact_p ^ fault_xor;

  ant_trunc_replica #(.N(REP_W)) u_rep (
    .rp_a (op_a[OP_W-1 -: REP_W]),
    .rp_b (op_b[OP_W-1 -: REP_W]),
    .rp_q (rep_q)
  );

  ant_decider #(.PW(PR_W), .RW(REP_W)) u_dec (
    .dc_main (main_p),
    .dc_rep  (rep_q),
    .dc_thr  (thr),
    .dc_out  (sel_p),
    .dc_alt  (sel_alt)
  );

  // next state, with the load enable written out
  always_comb begin
    valid_d = op_valid;
    prod_d  = res_prod;
    alt_d   = res_alt;
    if (op_valid) begin
      prod_d = sel_p;
      alt_d  = sel_alt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_prod  <= '0;
      res_alt   <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_prod  <= prod_d;
      res_alt   <= alt_d;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> ($stable(res_prod) && $stable(res_alt))); // R7

  AST_ALT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_alt |-> (res_prod[PR_W-REP_W-1:0] == '0)); // R6

  AST_MAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_alt) |-> (res_prod == $past(exact_p ^ fault_xor))); // R5

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[OP_W-1 -: REP_W] == '0) |-> (rep_q == '0)); // R3
endmodule

// File: tb/ant_trunc_mult_bench.sv
module ant_trunc_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [15:0] op_a, op_b;
  logic [31:0] thr, fault_xor;
  logic        res_valid;
  logic [31:0] res_prod;
  logic        res_alt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ant_trunc_mult u_ant_trunc_mult (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .thr(thr), .fault_xor(fault_xor), .res_valid(res_valid),
    .res_prod(res_prod), .res_alt(res_alt)
  );

  function automatic int rep_model(input logic [7:0] p, input logic [7:0] q);
    int s = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        if (p[i] && q[j]) begin
          if (i + j >= 8) s += (1 << (i + j - 8));
          else if (i + j == 7) s += 1;
        end
      end
    if ((p[6] && q[0]) || (p[0] && q[6])) s += 1;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [31:0] est_model(input logic [15:0] a, input logic [15:0] b);
    return 32'(rep_model(a[15:8], b[15:8])) << 24;
  endfunction

  function automatic logic [32:0] absd(input logic [31:0] x, input logic [31:0] y);
    return (x >= y) ? 33'(x - y) : 33'(y - x);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [31:0] t, input logic [31:0] f);
    logic [31:0] exact, m, e, want;
    logic alt;
    op_a = a; op_b = b; thr = t; fault_xor = f; op_valid = 1'b1;
    exact = 32'(a) * 32'(b);
    m = exact ^ f;
    e = est_model(a, b);
    alt = absd(m, e) > 33'(t);
    want = alt ? e : m;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1 valid", 32'(res_valid), 32'd1);
    chk("R5 product", res_prod, want);
    chk("R6 flag", 32'(res_alt), 32'(alt));
    if (res_alt) chk("R6 low bits zero", res_prod & 32'h00FF_FFFF, 32'd0);
    if (f == 0 && t >= 32'h1FFF_FFFF) chk("R2 exact", res_prod, exact);
    if (res_alt && t == 32'h1FFF_FFFF)
      chk("R8 bound", 32'(absd(res_prod, exact) < 33'h2000_0000), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] e, m, hold_p;
    logic hold_a;
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0; op_valid = 1'b0; op_a = '0; op_b = '0; thr = '0; fault_xor = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", 32'(res_valid), 32'd0);
    chk("R1 reset product", res_prod, 32'd0);
    chk("R1 reset flag", 32'(res_alt), 32'd0);

    // R4: saturating corner, checked through forced selection
    apply(16'hFFFF, 16'hFFFF, 32'd0, 32'h8000_0000);
    chk("R4 saturated estimate", res_prod, 32'hFF00_0000);
    // R3: exact replica value for a directed pattern (p=0x81, q=0x41)
    apply(16'h8100, 16'h4100, 32'd0, 32'hFF00_0000);
    chk("R3 replica", res_prod, 32'(rep_model(8'h81, 8'h41)) << 24);
    apply(16'h0000, 16'h0000, 32'h1FFF_FFFF, 32'd0);
    apply(16'hFFFF, 16'hFFFF, 32'h1FFF_FFFF, 32'd0);
    // R5: threshold equality keeps the main product
    m = 32'h1234 * 32'hABCD;
    e = est_model(16'h1234, 16'hABCD);
    apply(16'h1234, 16'hABCD, 32'(absd(m, e)), 32'd0);
    chk("R5 equal threshold", 32'(res_alt), 32'd0);
    apply(16'h1234, 16'hABCD, 32'(absd(m, e)) - 1, 32'd0);
    chk("R5 one below", 32'(res_alt), 32'd1);

    // R7: idle cycle with changed operands keeps outputs
    hold_p = res_prod; hold_a = res_alt;
    op_a = 16'h5555; op_b = 16'h3333; fault_xor = 32'hF000_0000; thr = 0;
    @(negedge clk);
    chk("R7 hold product", res_prod, hold_p);
    chk("R7 hold flag", 32'(res_alt), 32'(hold_a));
    chk("R1 idle valid", 32'(res_valid), 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] f;
      f = ($urandom % 2 == 0) ? 32'd0 : (32'd1 << (24 + ($urandom % 8)));
      apply(16'($urandom), 16'($urandom), 32'h1FFF_FFFF, f);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule